// File: doc/BRIEF.md
# Sampling Converter Control Model

This block is a synthesizable model of the digital control side of a 10-bit sampling converter. It can stand in for the converter in an emulation build, or act as a peer to a controller in a testbench. It watches a conversion-start line and a serial clock. It keeps a power state and times the wake-up and conversion intervals in system-clock cycles. When a conversion starts, it captures a parallel sample word. At the end of the conversion it hands the result to a serial output register. No analog behaviour is modelled.

The start line controls everything:

- A rising edge wakes the model from sleep and enables the serial output.
- A falling edge on an awake model captures the sample and starts the conversion timer.
- The level of the line at the end of the conversion decides the next state. If the line is high, the model stays awake. If it is low, the model goes back to sleep once the result is made available.

A result that completes while a serial read is still in progress stays pending. It moves to the output register only after the read has ended, so the word being shifted out is never corrupted.

The serial interface is a plain read port with no back-pressure. The reader supplies clock edges, and the model presents one bit per edge. Before each rising edge, `sdo` holds the bit that the edge consumes.

Top module: `cvt_ctrl_model`

## Requirements
- R1: After reset, `pstate` is sleep (encoding 0), `seq_err` is 0 and `sdo_oe` is 0.
- R2: A rising edge on `conv_start` in sleep moves `pstate` to waking (encoding 1) for `WAKE_CYC` cycles, and then to idle (encoding 2).
- R3: A falling edge on `conv_start` while asleep or waking sets `seq_err`, which stays at 1 until reset. No conversion starts.
- R4: A falling edge on `conv_start` in idle captures `sample_in` and moves `pstate` to converting (encoding 3) for `CONV_CYC` cycles.
- R5: At the end of a conversion, `pstate` goes to idle if `conv_start` is high, and to sleep if it is low.
- R6: One cycle after a conversion ends, the result is loaded into the output register, provided no read is active. If a read is active, the load waits until the read has finished, and the read completes with the old word.
- R7: `sdo_oe` rises one cycle after a rising edge on `conv_start`. It falls one cycle after a cycle in which `conv_start` is low and no read is active.
- R8: Each rising edge of `ser_clk` while `sdo_oe` is high shifts the output register one place. The word comes out MSB first. A read spans 10 edges, and `sdo` shows the next bit before each edge.
- R9: `ser_clk` edges while `sdo_oe` is low leave the output register and the read position unchanged.
- R10: Edges on `conv_start` during a conversion do not change `pstate` or `seq_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start | input | 1 | Conversion-start line, synchronous to clk |
| ser_clk | input | 1 | Serial read clock, synchronous to clk |
| sample_in | input | DATA_W | Sample word captured at conversion start |
| sdo | output | 1 | Serial data bit, forced to 0 while disabled |
| sdo_oe | output | 1 | Output enable; low means the pad floats |
| pstate | output | 2 | 0 sleep, 1 waking, 2 idle, 3 converting |
| seq_err | output | 1 | Sticky flag for a start edge that arrives too early |

## Verification
The assertions rely on the inputs meeting a few conditions:

- `conv_start` and `ser_clk` are synchronous to `clk`, and each level is held for at least one cycle.
- A serial edge never lands in the same cycle as a pending result load.
- `WAKE_CYC` and `CONV_CYC` are at least 2.

The stimulus meets these conditions by changing inputs only on the falling clock edge. It holds each serial-clock phase for a full cycle, and it starts reads only well clear of conversion ends. Every cycle, a behavioural reference model in the bench tracks the expected state, flag, enable and data bit.

// File: rtl/cvt_ctrl_pkg.sv
package cvt_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_WAKE  = 2'd1,
    ST_IDLE  = 2'd2,
    ST_CONV  = 2'd3
  } cvt_state_e;
endpackage

// File: rtl/cvt_edge_det.sv
module cvt_edge_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl;
  end

  for (genvar g = 0; g < N; g++) begin : g_edge
    assign rise[g] = lvl[g] & ~lvl_q[g];
    assign fall[g] = ~lvl[g] & lvl_q[g];
  end
endmodule

// File: rtl/cvt_interval_timer.sv
module cvt_interval_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (ld)         cnt <= ld_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R2 / R4: a loaded interval is never zero-length here
  a_r2_load_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && ld_val != '0) |=> !done);
endmodule

// File: rtl/cvt_shift_out.sv
module cvt_shift_out #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         shift,
  output logic         bit_out,
  output logic         busy
);
  localparam int BCW = $clog2(W + 1);

  logic [W-1:0]   sr;
  logic [BCW-1:0] pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr  <= '0;
      pos <= '0;
    end else if (load) begin
      sr  <= load_data;
    end else if (shift) begin
      sr  <= {sr[W-2:0], 1'b0};
      pos <= (pos == BCW'(W - 1)) ? '0 : pos + 1'b1;
    end
  end

  assign bit_out = sr[W-1];
  assign busy    = (pos != '0);

  // R6: the controller never reloads mid-read
  a_r6_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
  // R6: the word in flight holds between serial edges
  a_r6_hold_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !shift && !load) |=> $stable(sr));
  // R9: without an accepted edge the read position stays put
  a_r9_pos_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift && !load) |=> $stable(pos));
endmodule

// File: rtl/cvt_ctrl_model.sv
module cvt_ctrl_model
  import cvt_ctrl_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int WAKE_CYC = 375,
  parameter int CONV_CYC = 575
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start,
  input  logic              ser_clk,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [1:0]        pstate,
  output logic              seq_err
);
  localparam int TMAX = (WAKE_CYC > CONV_CYC) ? WAKE_CYC : CONV_CYC;
  localparam int CW   = $clog2(TMAX + 1);

  cvt_state_e        st;
  logic              err_q, oe_q, pend_q;
  logic [DATA_W-1:0] hold_q;
  logic [1:0]        rise, fall;
  logic              cs_rise, cs_fall, sk_acc;
  logic              tmr_ld, tmr_done, conv_end, load, busy, bit_out;
  logic [CW-1:0]     tmr_val;

  cvt_edge_det #(.N(2)) u_edges (
    .clk(clk), .rst_n(rst_n), .lvl({ser_clk, conv_start}),
    .rise(rise), .fall(fall)
  );

  assign cs_rise = rise[0];
  assign cs_fall = fall[0];
  assign sk_acc  = rise[1] & oe_q;

  assign tmr_ld  = ((st == ST_SLEEP) && cs_rise) || ((st == ST_IDLE) && cs_fall);
  assign tmr_val = (st == ST_SLEEP) ? CW'(WAKE_CYC - 1) : CW'(CONV_CYC - 1);

  cvt_interval_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ld(tmr_ld), .ld_val(tmr_val), .done(tmr_done)
  );

  assign conv_end = (st == ST_CONV) && tmr_done;
  assign load     = pend_q && !busy && !sk_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_SLEEP;
      err_q  <= 1'b0;
      oe_q   <= 1'b0;
      pend_q <= 1'b0;
      hold_q <= '0;
    end else begin
      unique case (st)
        ST_SLEEP: if (cs_rise) st <= ST_WAKE;
        ST_WAKE:  if (tmr_done) st <= ST_IDLE;
        ST_IDLE:  if (cs_fall) begin
                    st     <= ST_CONV;
                    hold_q <= sample_in;
                  end
        ST_CONV:  if (tmr_done) st <= conv_start ? ST_IDLE : ST_SLEEP;
        default:  st <= ST_SLEEP;
      endcase
      if (cs_fall && (st == ST_SLEEP || st == ST_WAKE)) err_q <= 1'b1;
      if (conv_end)  pend_q <= 1'b1;
      else if (load) pend_q <= 1'b0;
      if (cs_rise)                  oe_q <= 1'b1;
      else if (!conv_start && !busy) oe_q <= 1'b0;
    end
  end

  cvt_shift_out #(.W(DATA_W)) u_sout (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(hold_q),
    .shift(sk_acc), .bit_out(bit_out), .busy(busy)
  );

  assign sdo     = oe_q & bit_out;
  assign sdo_oe  = oe_q;
  assign pstate  = st;
  assign seq_err = err_q;

  // R2: the wake interval ends in idle
  a_r2_wake_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAKE && tmr_done) |=> (st == ST_IDLE));
  // R3: the error flag is sticky
  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);
  // R4: a start edge in idle begins a conversion
  a_r4_conv_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && cs_fall) |=> (st == ST_CONV));
  // R5: a low line at conversion end powers down
  a_r5_sleep_after: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_end && !conv_start) |=> (st == ST_SLEEP));
  // R7: the output enable follows a start rising edge
  a_r7_oe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> sdo_oe);
  // R10: a conversion runs to its end whatever the line does
  a_r10_conv_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CONV && !tmr_done) |=> (st == ST_CONV && $stable(seq_err)));
endmodule

// File: tb/cvt_ctrl_model_tb.sv
module cvt_ctrl_model_tb_top;
  localparam int W    = 10;
  localparam int WAKE = 12;
  localparam int CONV = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         conv_start = 1'b0;
  logic         ser_clk = 1'b0;
  logic [W-1:0] sample_in = '0;
  logic         sdo, sdo_oe, seq_err;
  logic [1:0]   pstate;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  cvt_ctrl_model #(.DATA_W(W), .WAKE_CYC(WAKE), .CONV_CYC(CONV)) dut_i (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .ser_clk(ser_clk),
    .sample_in(sample_in), .sdo(sdo), .sdo_oe(sdo_oe), .pstate(pstate),
    .seq_err(seq_err)
  );

  // behavioural reference
  int m_state, m_tmr, m_err, m_oe, m_pend, m_hold, m_sr, m_pos, p_cs, p_sk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_tmr = 0; m_err = 0; m_oe = 0; m_pend = 0;
      m_hold = 0; m_sr = 0; m_pos = 0; p_cs = 0; p_sk = 0;
    end else begin
      int ns, nt, nerr, noe, npend, nhold, nsr, npos;
      bit rs, fl, sk, ld;
      rs = conv_start && !p_cs;
      fl = !conv_start && p_cs;
      sk = ser_clk && !p_sk && (m_oe != 0);
      ld = (m_pend != 0) && m_pos == 0 && !sk;
      ns = m_state; nt = (m_tmr > 0) ? m_tmr - 1 : 0; nerr = m_err;
      noe = m_oe; npend = m_pend; nhold = m_hold; nsr = m_sr; npos = m_pos;
      case (m_state)
        0: if (rs) begin ns = 1; nt = WAKE - 1; end
        1: if (m_tmr == 0) ns = 2;
        2: if (fl) begin ns = 3; nt = CONV - 1; nhold = sample_in; end
        default: if (m_tmr == 0) begin npend = 1; ns = conv_start ? 2 : 0; end
      endcase
      if (fl && m_state <= 1) nerr = 1;
      if (!(m_state == 3 && m_tmr == 0) && ld) npend = 0;
      if (rs) noe = 1;
      else if (!conv_start && m_pos == 0) noe = 0;
      if (ld) nsr = m_hold;
      else if (sk) begin
        nsr = (m_sr << 1) & ((1 << W) - 1);
        npos = (m_pos == W - 1) ? 0 : m_pos + 1;
      end
      m_state = ns; m_tmr = nt; m_err = nerr; m_oe = noe; m_pend = npend;
      m_hold = nhold; m_sr = nsr; m_pos = npos; p_cs = conv_start; p_sk = ser_clk;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk("R2/R4/R5 model pstate", int'(pstate), m_state);
      chk("R3 model seq_err", int'(seq_err), m_err);
      chk("R7 model sdo_oe", int'(sdo_oe), m_oe);
      chk("R8 model sdo", int'(sdo), m_oe & ((m_sr >> (W - 1)) & 1));
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_read(input int n, output logic [W-1:0] v);
    v = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      v = {v[W-2:0], sdo};
      ser_clk = 1'b1;
      @(negedge clk);
      ser_clk = 1'b0;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    chk("R1 reset pstate", int'(pstate), 0);
    chk("R1 reset seq_err", int'(seq_err), 0);
    chk("R1 reset sdo_oe", int'(sdo_oe), 0);

    // wake-up
    conv_start = 1'b1;
    wait_cyc(2);
    chk("R2 waking", int'(pstate), 1);
    chk("R7 oe after rise", int'(sdo_oe), 1);
    wait_cyc(WAKE + 2);
    chk("R2 idle after wake", int'(pstate), 2);

    // conversion with the line kept high
    sample_in = 10'h2A5;
    conv_start = 1'b0;
    wait_cyc(1);
    sample_in = 10'h000;
    wait_cyc(1);
    chk("R4 converting", int'(pstate), 3);
    conv_start = 1'b1;
    wait_cyc(CONV + 4);
    chk("R5 idle after conv", int'(pstate), 2);
    do_read(W, v);
    chk("R8 read word", int'(v), 'h2A5);

    // read spanning the end of a conversion; edges during conversion
    sample_in = 10'h15A;
    conv_start = 1'b0;
    wait_cyc(2);
    conv_start = 1'b1;
    wait_cyc(2);
    conv_start = 1'b0;
    wait_cyc(2);
    chk("R10 still converting", int'(pstate), 3);
    chk("R10 no error", int'(seq_err), 0);
    conv_start = 1'b1;
    wait_cyc(1);
    do_read(5, v);
    wait_cyc(10);
    chk("R5 idle after conv 2", int'(pstate), 2);
    do_read(5, v);
    chk("R6 old word finished", int'(v), 0);
    wait_cyc(2);
    do_read(W, v);
    chk("R6 deferred word", int'(v), 'h15A);

    // power-down mode
    sample_in = 10'h3C3;
    conv_start = 1'b0;
    wait_cyc(CONV + 4);
    chk("R5 sleep after conv", int'(pstate), 0);
    chk("R7 oe low asleep", int'(sdo_oe), 0);
    do_read(3, v);
    conv_start = 1'b1;
    wait_cyc(2);
    chk("R2 waking again", int'(pstate), 1);
    wait_cyc(WAKE + 3);
    chk("R2 idle again", int'(pstate), 2);
    do_read(W, v);
    chk("R9 word intact", int'(v), 'h3C3);

    // early start edge
    conv_start = 1'b0;
    wait_cyc(CONV + 4);
    chk("R5 sleep again", int'(pstate), 0);
    conv_start = 1'b1;
    wait_cyc(3);
    conv_start = 1'b0;
    wait_cyc(2);
    chk("R3 error set", int'(seq_err), 1);
    chk("R3 still waking", int'(pstate), 1);
    wait_cyc(WAKE + 20);
    chk("R3 no conversion", int'(pstate), 2);
    chk("R3 error sticky", int'(seq_err), 1);

    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule